// File: doc/BRIEF.md
# UART Channel Interrupt Prioritizer

This block gathers every interrupt source of a single UART channel and reduces them to one interrupt line and one status code. The sources are line-status errors, receive data at its trigger level, receive timeout, transmit holding register empty, a modem-input change, detection of a flow-stop (Xoff) character and an RTS/CTS flow-pin change. Each source is masked by its own enable bit. The status code names the most urgent unmasked source that is pending.

Level sources come straight from the receiver and line logic, and the block does not latch them. Event sources are held in sticky flags until the host action that retires them takes place. The block also keeps the four modem-input change flags. These flags record any toggle of the modem inputs, and a read of the modem status register clears them.

The host reads the status code through `isr_code`. It pulses `isr_rd` on the cycle of that read and `msr_rd` on the cycle of a modem-status read. The interrupt pin is qualified by an output-gating bit.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset `isr_code` is 0x01, `irq` is low and `msr_delta` is 0.
- R2: Sources are ranked from highest to lowest priority, with these codes: line error 0x06, receive timeout 0x0C, receive data 0x04, transmit empty 0x02, modem change 0x00, Xoff detected 0x10, flow-pin change 0x20. The code 0x01 means nothing is pending, so bit 0 is 1 only when idle.
- R3: Each bit of `irq_en` unmasks sources: bit0 covers receive data and timeout, bit1 transmit empty, bit2 line error, bit3 modem change, bit4 Xoff, bit5 flow-pin change. A masked source is never reported. With all bits clear the code is 0x01 and `irq` stays low.
- R4: `irq` is high exactly when `irq_gate` is 1 and some unmasked source is pending. The status code does not depend on `irq_gate`.
- R5: Each `msr_delta` bit is set one clock after its `modem_in` bit changes. Input levels that are present when reset is released set no bit.
- R6: A pulse on `msr_rd` clears all `msr_delta` bits at the next clock. A change that arrives in the same cycle as the read is still recorded.
- R7: The modem-change source is pending while any `msr_delta` bit is 1.
- R8: The transmit-empty event is latched on a rising edge of `thr_empty`. It is cleared by an `isr_rd` in a cycle where the code is 0x02, or by a `thr_wr` pulse.
- R9: An `isr_rd` while a different code is shown leaves the transmit-empty and flow-pin events pending.
- R10: The Xoff flag is set by an `xoff_det` pulse and cleared only by an `xon_det` pulse. A status read does not clear it.
- R11: The flow-pin event is latched on a `flow_chg` pulse. It is cleared by an `isr_rd` in a cycle where the code is 0x20.
- R12: Line error, receive data and receive timeout follow their inputs in the same cycle and are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 6 | Source enable bits |
| irq_gate | input | 1 | Output gating bit for `irq` |
| line_err | input | 1 | Line-status error present (level) |
| rx_trig | input | 1 | Receive data at trigger (level) |
| rx_tmo | input | 1 | Receive timeout (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_wr | input | 1 | Write strobe to the transmit holding register |
| modem_in | input | 4 | Modem input levels |
| msr_rd | input | 1 | Modem-status read strobe |
| xoff_det | input | 1 | Xoff character detected (pulse) |
| xon_det | input | 1 | Xon character detected (pulse) |
| flow_chg | input | 1 | RTS/CTS pin change (pulse) |
| isr_rd | input | 1 | Status-code read strobe |
| isr_code | output | 6 | Code of the highest pending source |
| irq | output | 1 | Channel interrupt |
| msr_delta | output | 4 | Modem-input change flags |

## Verification
A sticky flag that is stuck or lost shows as a wrong `isr_code` on the first cycle after the setting or clearing edge. When that flag outranks the others in the enable mask, the code and `irq` disagree with the expected ranking at once. A broken mask bit or a wrong priority order shows only with a particular mix of pending sources and enables. For that reason every combination of the seven conditions is crossed with all 64 enable masks. Faults in clearing show within one clock of the `isr_rd`, `msr_rd`, `thr_wr` or `xon_det` pulse that should retire the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 7;
  localparam int NMODEM = 4;
  localparam int CODE_W = 6;
  localparam int EN_W   = 6;

  typedef enum logic [CODE_W-1:0] {
    CODE_MODEM = 6'h00,
    CODE_NONE  = 6'h01,
    CODE_THR   = 6'h02,
    CODE_RXDAT = 6'h04,
    CODE_LINE  = 6'h06,
    CODE_RXTMO = 6'h0C,
    CODE_XOFF  = 6'h10,
    CODE_FLOW  = 6'h20
  } irq_code_e;

  // pending vector index, 0 = highest priority
  localparam int P_LINE  = 0;
  localparam int P_RXTMO = 1;
  localparam int P_RXDAT = 2;
  localparam int P_THR   = 3;
  localparam int P_MODEM = 4;
  localparam int P_XOFF  = 5;
  localparam int P_FLOW  = 6;

  function automatic irq_code_e code_of(input int idx);
    case (idx)
      P_LINE:  return CODE_LINE;
      P_RXTMO: return CODE_RXTMO;
      P_RXDAT: return CODE_RXDAT;
      P_THR:   return CODE_THR;
      P_MODEM: return CODE_MODEM;
      P_XOFF:  return CODE_XOFF;
      P_FLOW:  return CODE_FLOW;
      default: return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/intr_evt_latch.sv
module intr_evt_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;
  logic         q_ce;

  always_comb begin
    q_ce  = |(set_i | clr_i);
    q_nxt = (q_r & ~clr_i) | set_i;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_ce) q_r <= q_nxt;
  end

  assign q_o = q_r;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R8
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    // R10
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
  end
endmodule

// File: rtl/intr_msr_delta.sv
module intr_msr_delta #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic         rd_i,
  output logic [N-1:0] delta_o
);
  logic [N-1:0] prev_r, delta_r, delta_nxt, chg;
  logic         primed_r;

  always_comb begin
    chg       = primed_r ? (line_i ^ prev_r) : '0;
    delta_nxt = (rd_i ? '0 : delta_r) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r   <= '0;
      delta_r  <= '0;
      primed_r <= 1'b0;
    end else begin
      prev_r   <= line_i;
      delta_r  <= delta_nxt;
      primed_r <= 1'b1;
    end
  end

  assign delta_o = delta_r;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5
    delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_r && line_i[i] != prev_r[i]) |=> delta_o[i]);
    // R6
    delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && line_i[i] == prev_r[i]) |=> delta_o[i] == $past(delta_o[i]));
  end
  // R6
  delta_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (!primed_r || line_i == prev_r)) |=> delta_o == '0);
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      grant_o,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    grant_o = '0;
    code_o  = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        code_o  = code_of(i);
      end
    end
    any_o = |grant_o;
  end

  always_comb begin
    // R2
    grant_onehot_chk: assert ($onehot0(grant_o));
    // R2
    idle_code_chk: assert ((pend_i == '0) == (code_o == CODE_NONE));
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EN_W-1:0]   irq_en,
  input  logic              irq_gate,
  input  logic              line_err,
  input  logic              rx_trig,
  input  logic              rx_tmo,
  input  logic              thr_empty,
  input  logic              thr_wr,
  input  logic [NMODEM-1:0] modem_in,
  input  logic              msr_rd,
  input  logic              xoff_det,
  input  logic              xon_det,
  input  logic              flow_chg,
  input  logic              isr_rd,
  output logic [CODE_W-1:0] isr_code,
  output logic              irq,
  output logic [NMODEM-1:0] msr_delta
);
  localparam int NEVT = 3;   // thr, xoff, flow

  logic              rs1_r, rs2_r, rst_q;
  logic              thr_prev_r, thr_rise;
  logic [NEVT-1:0]   evt_set, evt_clr, evt_q;
  logic [NSRC-1:0]   pend, grant;
  logic [CODE_W-1:0] code;
  logic              any;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_r <= 1'b0;
      rs2_r <= 1'b0;
    end else begin
      rs1_r <= 1'b1;
      rs2_r <= rs1_r;
    end
  end
  assign rst_q = rs2_r;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) thr_prev_r <= 1'b1;
    else        thr_prev_r <= thr_empty;
  end

  always_comb begin
    thr_rise   = thr_empty & ~thr_prev_r;
    evt_set    = {flow_chg, xoff_det, thr_rise};
    evt_clr[0] = thr_wr | (isr_rd & (code == CODE_THR));
    evt_clr[1] = xon_det;
    evt_clr[2] = isr_rd & (code == CODE_FLOW);
  end

  intr_evt_latch #(.W(NEVT)) u_evt (
    .clk(clk), .rst_n(rst_q), .set_i(evt_set), .clr_i(evt_clr), .q_o(evt_q)
  );

  intr_msr_delta #(.N(NMODEM)) u_msr (
    .clk(clk), .rst_n(rst_q), .line_i(modem_in), .rd_i(msr_rd), .delta_o(msr_delta)
  );

  always_comb begin
    pend          = '0;
    pend[P_LINE]  = line_err  & irq_en[2];
    pend[P_RXTMO] = rx_tmo    & irq_en[0];
    pend[P_RXDAT] = rx_trig   & irq_en[0];
    pend[P_THR]   = evt_q[0]  & irq_en[1];
    pend[P_MODEM] = |msr_delta & irq_en[3];
    pend[P_XOFF]  = evt_q[1]  & irq_en[4];
    pend[P_FLOW]  = evt_q[2]  & irq_en[5];
  end

  intr_prio_enc #(.N(NSRC)) u_enc (
    .pend_i(pend), .grant_o(grant), .code_o(code), .any_o(any)
  );

  assign isr_code = code;
  assign irq      = irq_gate & any;

  // R4
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> isr_code[0] == 1'b0);
  // R2
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (line_err && irq_en[2]) |-> isr_code == CODE_LINE);
  // R10
  xon_clr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (xon_det && !xoff_det) |=> isr_code != CODE_XOFF);
  // R8
  thr_rd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (isr_rd && isr_code == CODE_THR && !thr_rise) |=> isr_code != CODE_THR);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq_en;
  logic       irq_gate, line_err, rx_trig, rx_tmo, thr_empty, thr_wr;
  logic [3:0] modem_in;
  logic       msr_rd, xoff_det, xon_det, flow_chg, isr_rd;
  logic [5:0] isr_code;
  logic       irq;
  logic [3:0] msr_delta;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_gate(irq_gate),
    .line_err(line_err), .rx_trig(rx_trig), .rx_tmo(rx_tmo),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .modem_in(modem_in),
    .msr_rd(msr_rd), .xoff_det(xoff_det), .xon_det(xon_det),
    .flow_chg(flow_chg), .isr_rd(isr_rd), .isr_code(isr_code),
    .irq(irq), .msr_delta(msr_delta)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_code(input string req, input logic [5:0] exp);
    check(isr_code == exp, req, isr_code, exp);
  endtask

  function automatic logic [5:0] exp_code(input logic [6:0] c, input logic [5:0] en);
    if (c[0] & en[2])      return 6'h06;
    else if (c[1] & en[0]) return 6'h0C;
    else if (c[2] & en[0]) return 6'h04;
    else if (c[3] & en[1]) return 6'h02;
    else if (c[4] & en[3]) return 6'h00;
    else if (c[5] & en[4]) return 6'h10;
    else if (c[6] & en[5]) return 6'h20;
    else                   return 6'h01;
  endfunction

  task automatic do_reset(input logic [3:0] m0);
    rst_n = 1'b0;
    irq_en = '0; irq_gate = 0; line_err = 0; rx_trig = 0; rx_tmo = 0;
    thr_empty = 0; thr_wr = 0; modem_in = m0; msr_rd = 0;
    xoff_det = 0; xon_det = 0; flow_chg = 0; isr_rd = 0;
    #5;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_isr_rd();
    @(negedge clk) isr_rd = 1;
    @(negedge clk) isr_rd = 0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(4'h0);
    chk_code("R1", 6'h01);
    check(irq == 0, "R1", irq, 0);
    check(msr_delta == 0, "R1", msr_delta, 0);

    // R2 R3 R4 R7 R12: every pending mix crossed with every mask
    for (int c = 0; c < 128; c++) begin
      logic [6:0] cv;
      cv = c[6:0];
      do_reset(4'h0);
      @(negedge clk);
      line_err = cv[0]; rx_tmo = cv[1]; rx_trig = cv[2];
      thr_empty = cv[3]; modem_in[0] = cv[4]; xoff_det = cv[5]; flow_chg = cv[6];
      @(negedge clk);
      xoff_det = 0; flow_chg = 0;
      for (int e = 0; e < 64; e++) begin
        logic [5:0] ev;
        logic [5:0] ex;
        ev = e[5:0];
        irq_en = ev;
        irq_gate = ev[0] ^ cv[0] ^ cv[3];
        #1;
        ex = exp_code(cv, ev);
        chk_code("R2 R3", ex);
        check(irq == (irq_gate && ex != 6'h01), "R4", irq, irq_gate && ex != 6'h01);
        #1;
      end
    end

    // R5: levels at reset release set nothing; R6 R7
    do_reset(4'hF);
    #1 check(msr_delta == 0, "R5", msr_delta, 0);
    irq_en = 6'h08; irq_gate = 1;
    @(negedge clk) modem_in = 4'b1011;
    @(negedge clk) #1;
    check(msr_delta == 4'b0100, "R5", msr_delta, 4'b0100);
    chk_code("R7", 6'h00);
    check(irq == 1, "R7", irq, 1);
    @(negedge clk) msr_rd = 1;
    @(negedge clk) msr_rd = 0;
    #1 check(msr_delta == 0, "R6", msr_delta, 0);
    chk_code("R7", 6'h01);
    @(negedge clk) begin msr_rd = 1; modem_in = 4'b1010; end
    @(negedge clk) msr_rd = 0;
    #1 check(msr_delta == 4'b0001, "R6", msr_delta, 4'b0001);

    // R8: clear by reporting read, then by write
    do_reset(4'h0);
    irq_en = 6'h02; irq_gate = 1;
    @(negedge clk) thr_empty = 1;
    @(negedge clk) #1 chk_code("R8", 6'h02);
    pulse_isr_rd();
    chk_code("R8", 6'h01);
    @(negedge clk) thr_empty = 0;
    @(negedge clk) thr_empty = 1;
    @(negedge clk) #1 chk_code("R8", 6'h02);
    @(negedge clk) thr_wr = 1;
    @(negedge clk) thr_wr = 0;
    #1 chk_code("R8", 6'h01);

    // R9: read reporting a higher source keeps transmit-empty and flow events
    do_reset(4'h0);
    irq_en = 6'h26; irq_gate = 1;
    @(negedge clk) begin thr_empty = 1; flow_chg = 1; line_err = 1; end
    @(negedge clk) flow_chg = 0;
    #1 chk_code("R9", 6'h06);
    pulse_isr_rd();
    line_err = 0;
    #1 chk_code("R9", 6'h02);
    irq_en = 6'h24;
    #1 chk_code("R9", 6'h20);

    // R10: Xoff flag survives a read, cleared by Xon
    do_reset(4'h0);
    irq_en = 6'h10; irq_gate = 1;
    @(negedge clk) xoff_det = 1;
    @(negedge clk) xoff_det = 0;
    #1 chk_code("R10", 6'h10);
    pulse_isr_rd();
    chk_code("R10", 6'h10);
    @(negedge clk) xon_det = 1;
    @(negedge clk) xon_det = 0;
    #1 chk_code("R10", 6'h01);

    // R11: flow event cleared by reporting read
    do_reset(4'h0);
    irq_en = 6'h20; irq_gate = 1;
    @(negedge clk) flow_chg = 1;
    @(negedge clk) flow_chg = 0;
    #1 chk_code("R11", 6'h20);
    check(irq == 1, "R11", irq, 1);
    pulse_isr_rd();
    chk_code("R11", 6'h01);

    // R12: level sources follow inputs in the same cycle
    do_reset(4'h0);
    irq_en = 6'h05; irq_gate = 1;
    @(negedge clk) line_err = 1;
    #1 chk_code("R12", 6'h06);
    line_err = 0;
    #1 chk_code("R12", 6'h01);
    rx_tmo = 1;
    #1 chk_code("R12", 6'h0C);
    rx_tmo = 0; rx_trig = 1;
    #1 chk_code("R12", 6'h04);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule